// File: doc/BRIEF.md
# Shared-Memory Atomic Operation Unit

This block sits on the memory side of a small word-addressed store that several requesters share. Each requester owns one port. A request carries an opcode, a word address and a write value. The unit picks one request per cycle and completes that request's read-modify-write as a single indivisible step. Because of this, the chosen request is never interleaved with an access from any other port.

Two families of synchronisation primitive are offered. The swap-style primitives are atomic exchange, test-and-set and fetch-and-increment. With exchange, a lock word that holds 0 (free) and is swapped with 1 tells the caller it now owns the lock when the value returned is 0. The second family is load-linked and store-conditional. Each port keeps one address reservation. A store-conditional succeeds only if no other port has written that word since the port's load-linked.

Responses come back one cycle after the handshake, on the port that made the request. The returned word is either the old memory value or a success flag of 0 or 1.

Top module: `atomic_mem_unit`

## Requirements
- R1: At most one port sees `req_ready` high in any cycle, and `req_ready` of a port is high only while that port's `req_valid` is high; a handshake is `req_valid && req_ready`.
- R2: With `ARB_RR`=1 the grant rotates: priority starts at the port after the one granted most recently, so a port just served loses to any other valid port in the next cycle; after reset port 0 has top priority.
- R3: A handshake on port p in cycle n raises `rsp_valid` of port p alone for one cycle in cycle n+1, with the result on that port's slice of `rsp_data`.
- R4: Opcode field of 3 bits: 0 read, 1 write, 2 exchange, 3 test-and-set, 4 fetch-and-increment, 5 load-linked, 6 store-conditional, 7 behaves as read. A read returns the word; a write stores the write value and returns the old word.
- R5: Exchange stores the write value and returns the prior word in one step.
- R6: Test-and-set returns the prior word and stores the write value only when the prior word is zero.
- R7: Fetch-and-increment returns the prior word and stores it plus one, wrapping to zero past the all-ones value.
- R8: Load-linked returns the word and sets that port's reservation to the address, replacing any earlier one.
- R9: Store-conditional with a live reservation on the same address stores the value and returns 1; otherwise it returns 0 and memory is unchanged. Either way the port's reservation is cleared.
- R10: Every memory write (write, exchange, successful test-and-set, fetch-and-increment, successful store-conditional) clears the reservations of all other ports that hold that address; the writer's own reservation, reservations on other addresses and failed writes are untouched.
- R11: Synchronous reset clears every word to zero, drops all reservations and responses, and grants nothing while it is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | NUM_PORTS | Request present, one bit per port |
| req_ready | output | NUM_PORTS | Request accepted this cycle, one bit per port |
| req_op | input | 3*NUM_PORTS | Opcode per port, port p at bits [3p+2:3p] |
| req_addr | input | ADDR_W*NUM_PORTS | Word address per port |
| req_wdata | input | DATA_W*NUM_PORTS | Write value per port |
| rsp_valid | output | NUM_PORTS | Response strobe, one bit per port |
| rsp_data | output | DATA_W*NUM_PORTS | Returned word or success flag per port |

## Verification
The bench targets reservation corners. These are a store-conditional retried after its own success, a reservation broken by another port's plain write or fetch-and-increment, a write to a different address, a replacement load-linked, and the port's own write. A design that got these wrong would let a stale store-conditional overwrite data or would refuse a valid one. A failed test-and-set is checked too: it must neither change the word nor break a reservation, and a design that stored anyway would release a held lock. The bench also covers the fetch-and-increment wrap at all-ones and the rotation of grants among contending ports. A broken arbiter would starve a port or grant the same port twice in a row.

// File: rtl/atomic_pkg.sv
package atomic_pkg;

   typedef enum logic [2:0] {
      OP_READ  = 3'd0,
      OP_WRITE = 3'd1,
      OP_SWAP  = 3'd2,
      OP_TAS   = 3'd3,
      OP_FINC  = 3'd4,
      OP_LL    = 3'd5,
      OP_SC    = 3'd6,
      OP_RSVD  = 3'd7
   } atom_op_e;

   localparam int OP_W = 3;

endpackage

// File: rtl/atomic_arbiter.sv
module atomic_arbiter #(
   parameter int NUM_PORTS = 3,
   parameter bit ARB_RR    = 1'b1,
   localparam int IDX_W    = $clog2(NUM_PORTS)
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic [NUM_PORTS-1:0] req,
   output logic [NUM_PORTS-1:0] gnt,
   output logic [IDX_W-1:0]     gnt_idx
);

   initial begin
      assert (NUM_PORTS >= 2) else $error("atomic_arbiter needs two or more ports");
   end

   generate
      if (ARB_RR) begin : g_rr
         logic [IDX_W-1:0] last_q;
         int               idx;
         logic             found;

         always_comb begin
            gnt     = '0;
            gnt_idx = '0;
            found   = 1'b0;
            idx     = 0;
            for (int k = 1; k <= NUM_PORTS; k++) begin
               idx = (int'(last_q) + k) % NUM_PORTS;
               if (!found && req[idx]) begin
                  gnt[idx] = 1'b1;
                  gnt_idx  = IDX_W'(idx);
                  found    = 1'b1;
               end
            end
         end

         always_ff @(posedge clk) begin
            if (rst) begin
               last_q <= IDX_W'(NUM_PORTS - 1);
            end else if (|gnt) begin
               last_q <= gnt_idx;
            end
         end
      end else begin : g_fixed
         logic found;

         always_comb begin
            gnt     = '0;
            gnt_idx = '0;
            found   = 1'b0;
            for (int k = 0; k < NUM_PORTS; k++) begin
               if (!found && req[k]) begin
                  gnt[k]  = 1'b1;
                  gnt_idx = IDX_W'(k);
                  found   = 1'b1;
               end
            end
         end
      end
   endgenerate

endmodule

// File: rtl/atomic_alu.sv
module atomic_alu
   import atomic_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  atom_op_e            op,
   input  logic [DATA_W-1:0]   old_word,
   input  logic [DATA_W-1:0]   wdata,
   input  logic                resv_hit,
   output logic                wr_en,
   output logic [DATA_W-1:0]   wr_word,
   output logic [DATA_W-1:0]   result
);

   initial begin
      assert (DATA_W >= 2) else $error("atomic_alu needs a data width of two or more");
   end

   always_comb begin
      wr_en   = 1'b0;
      wr_word = wdata;
      result  = old_word;
      case (op)
         OP_WRITE: wr_en = 1'b1;
         OP_SWAP:  wr_en = 1'b1;
         OP_TAS:   wr_en = (old_word == '0);
         OP_FINC: begin
            wr_en   = 1'b1;
            wr_word = old_word + DATA_W'(1);
         end
         OP_SC: begin
            wr_en  = resv_hit;
            result = {{(DATA_W-1){1'b0}}, resv_hit};
         end
         default: wr_en = 1'b0;
      endcase
   end

endmodule

// File: rtl/atomic_resv.sv
module atomic_resv
   import atomic_pkg::*;
#(
   parameter int NUM_PORTS = 3,
   parameter int ADDR_W    = 4,
   localparam int IDX_W    = $clog2(NUM_PORTS)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              fire,
   input  logic [IDX_W-1:0]  port,
   input  atom_op_e          op,
   input  logic [ADDR_W-1:0] addr,
   input  logic              wr_en,
   output logic              hit
);

   logic [NUM_PORTS-1:0] live_q;
   logic [ADDR_W-1:0]    addr_q [NUM_PORTS];
   logic [NUM_PORTS-1:0] match;

   genvar g;
   generate
      for (g = 0; g < NUM_PORTS; g++) begin : g_slot
         logic own;
         assign own      = (port == IDX_W'(g));
         assign match[g] = live_q[g] && (addr_q[g] == addr);

         always_ff @(posedge clk) begin
            if (rst) begin
               live_q[g] <= 1'b0;
               addr_q[g] <= '0;
            end else if (fire) begin
               if (own) begin
                  if (op == OP_LL) begin
                     live_q[g] <= 1'b1;
                     addr_q[g] <= addr;
                  end else if (op == OP_SC) begin
                     live_q[g] <= 1'b0;
                  end
               end else if (wr_en && match[g]) begin
                  live_q[g] <= 1'b0;
               end
            end
         end
      end
   endgenerate

   assign hit = match[port];

endmodule

// File: rtl/atomic_mem_unit.sv
module atomic_mem_unit
   import atomic_pkg::*;
#(
   parameter int NUM_PORTS = 3,
   parameter int DATA_W    = 8,
   parameter int ADDR_W    = 4,
   parameter bit ARB_RR    = 1'b1
) (
   input  logic                        clk,
   input  logic                        rst,
   input  logic [NUM_PORTS-1:0]        req_valid,
   output logic [NUM_PORTS-1:0]        req_ready,
   input  logic [NUM_PORTS*OP_W-1:0]   req_op,
   input  logic [NUM_PORTS*ADDR_W-1:0] req_addr,
   input  logic [NUM_PORTS*DATA_W-1:0] req_wdata,
   output logic [NUM_PORTS-1:0]        rsp_valid,
   output logic [NUM_PORTS*DATA_W-1:0] rsp_data
);

   localparam int IDX_W = $clog2(NUM_PORTS);
   localparam int DEPTH = 2 ** ADDR_W;

   initial begin
      assert (ADDR_W >= 1 && ADDR_W <= 10) else $error("atomic_mem_unit address width out of range");
      assert (NUM_PORTS <= 16) else $error("atomic_mem_unit port count out of range");
   end

   logic [NUM_PORTS-1:0] arb_req;
   logic [NUM_PORTS-1:0] gnt;
   logic [IDX_W-1:0]     gnt_idx;
   logic                 fire;

   atom_op_e            sel_op;
   logic [ADDR_W-1:0]   sel_addr;
   logic [DATA_W-1:0]   sel_wdata;
   logic [DATA_W-1:0]   old_word;
   logic                resv_hit;
   logic                wr_en;
   logic [DATA_W-1:0]   wr_word;
   logic [DATA_W-1:0]   result;

   logic [DATA_W-1:0]    mem_q [DEPTH];
   logic [NUM_PORTS-1:0] rsp_valid_q;

   assign arb_req   = rst ? '0 : req_valid;
   assign fire      = |gnt;
   assign req_ready = gnt;

   atomic_arbiter #(
      .NUM_PORTS (NUM_PORTS),
      .ARB_RR    (ARB_RR)
   ) u_arb (
      .clk     (clk),
      .rst     (rst),
      .req     (arb_req),
      .gnt     (gnt),
      .gnt_idx (gnt_idx)
   );

   always_comb begin
      sel_op    = atom_op_e'(req_op[gnt_idx*OP_W +: OP_W]);
      sel_addr  = req_addr[gnt_idx*ADDR_W +: ADDR_W];
      sel_wdata = req_wdata[gnt_idx*DATA_W +: DATA_W];
   end

   assign old_word = mem_q[sel_addr];

   atomic_resv #(
      .NUM_PORTS (NUM_PORTS),
      .ADDR_W    (ADDR_W)
   ) u_resv (
      .clk   (clk),
      .rst   (rst),
      .fire  (fire),
      .port  (gnt_idx),
      .op    (sel_op),
      .addr  (sel_addr),
      .wr_en (wr_en),
      .hit   (resv_hit)
   );

   atomic_alu #(
      .DATA_W (DATA_W)
   ) u_alu (
      .op       (sel_op),
      .old_word (old_word),
      .wdata    (sel_wdata),
      .resv_hit (resv_hit),
      .wr_en    (wr_en),
      .wr_word  (wr_word),
      .result   (result)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         for (int i = 0; i < DEPTH; i++) begin
            mem_q[i] <= '0;
         end
      end else if (fire && wr_en) begin
         mem_q[sel_addr] <= wr_word;
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         rsp_valid_q <= '0;
      end else begin
         rsp_valid_q <= gnt;
      end
   end

   assign rsp_valid = rsp_valid_q;

   genvar g;
   generate
      for (g = 0; g < NUM_PORTS; g++) begin : g_rsp
         logic [DATA_W-1:0] data_q;
         always_ff @(posedge clk) begin
            if (rst) begin
               data_q <= '0;
            end else if (gnt[g]) begin
               data_q <= result;
            end
         end
         assign rsp_data[g*DATA_W +: DATA_W] = data_q;
      end
   endgenerate

endmodule

// File: rtl/atomic_mem_unit_chk.sv
module atomic_mem_unit_chk
   import atomic_pkg::*;
#(
   parameter int NUM_PORTS = 3,
   parameter int DATA_W    = 8,
   parameter bit ARB_RR    = 1'b1
) (
   input logic                        clk,
   input logic                        rst,
   input logic [NUM_PORTS-1:0]        req_valid,
   input logic [NUM_PORTS-1:0]        req_ready,
   input logic [NUM_PORTS*OP_W-1:0]   req_op,
   input logic [NUM_PORTS-1:0]        rsp_valid,
   input logic [NUM_PORTS*DATA_W-1:0] rsp_data
);

   assert_one_grant_R1: assert property (@(posedge clk) disable iff (rst)
      $onehot0(req_ready));

   assert_ready_needs_valid_R1: assert property (@(posedge clk) disable iff (rst)
      (req_ready & ~req_valid) == '0);

   genvar g;
   generate
      for (g = 0; g < NUM_PORTS; g++) begin : g_port
         localparam logic [NUM_PORTS-1:0] SELF = NUM_PORTS'(1) << g;

         assert_rsp_follows_R3: assert property (@(posedge clk) disable iff (rst)
            req_ready[g] |=> rsp_valid[g]);

         assert_no_stray_rsp_R3: assert property (@(posedge clk) disable iff (rst)
            rsp_valid[g] |-> $past(req_ready[g]));

         assert_sc_flag_R9: assert property (@(posedge clk) disable iff (rst)
            (req_ready[g] && req_op[g*OP_W +: OP_W] == OP_SC)
            |=> (rsp_data[g*DATA_W+1 +: DATA_W-1] == '0));

         if (ARB_RR) begin : g_rr
            assert_rr_yield_R2: assert property (@(posedge clk) disable iff (rst)
               req_ready[g] |=> (!req_ready[g] || (req_valid & ~SELF) == '0));
         end
      end
   endgenerate

endmodule

bind atomic_mem_unit atomic_mem_unit_chk #(
   .NUM_PORTS (NUM_PORTS),
   .DATA_W    (DATA_W),
   .ARB_RR    (ARB_RR)
) u_chk (
   .clk       (clk),
   .rst       (rst),
   .req_valid (req_valid),
   .req_ready (req_ready),
   .req_op    (req_op),
   .rsp_valid (rsp_valid),
   .rsp_data  (rsp_data)
);

// File: tb/atomic_mem_unit_tb.sv
module atomic_mem_unit_tb;

   localparam int NP = 3;
   localparam int DW = 8;
   localparam int AW = 4;

   logic            clk = 1'b0;
   logic            rst = 1'b1;
   logic [NP-1:0]   req_valid = '0;
   logic [NP-1:0]   req_ready;
   logic [NP*3-1:0] req_op = '0;
   logic [NP*AW-1:0] req_addr = '0;
   logic [NP*DW-1:0] req_wdata = '0;
   logic [NP-1:0]   rsp_valid;
   logic [NP*DW-1:0] rsp_data;

   int n_chk = 0;
   int n_bad = 0;

   always #4 clk = ~clk;

   atomic_mem_unit #(
      .NUM_PORTS (NP),
      .DATA_W    (DW),
      .ADDR_W    (AW),
      .ARB_RR    (1'b1)
   ) u_dut (
      .clk       (clk),
      .rst       (rst),
      .req_valid (req_valid),
      .req_ready (req_ready),
      .req_op    (req_op),
      .req_addr  (req_addr),
      .req_wdata (req_wdata),
      .rsp_valid (rsp_valid),
      .rsp_data  (rsp_data)
   );

   // entry: {req tag nibble, port, op, addr, wdata, expected}
   // ops: 0 read 1 write 2 exchange 3 test-and-set 4 fetch-inc 5 load-linked 6 store-cond
   localparam int NV = 46;
   localparam logic [31:0] VEC [NV] = '{
      32'hB_0_0_3_00_00, // R11 memory cleared by reset
      32'h4_0_1_3_5A_00, // R4 write returns old word
      32'h4_1_0_3_00_5A, // R4 read from another port
      32'h5_1_2_3_01_5A, // R5 exchange
      32'h5_2_0_3_00_01, // R5 new value visible
      32'h5_0_2_7_01_00, // R5 lock acquired
      32'h5_1_2_7_01_01, // R5 lock already held
      32'h6_2_3_8_AA_00, // R6 test passes
      32'h6_0_3_8_55_AA, // R6 test fails
      32'h6_1_0_8_00_AA, // R6 word unchanged
      32'h7_2_4_9_00_00, // R7 fetch-inc
      32'h7_2_4_9_00_01, // R7 again
      32'h4_0_1_9_FF_02, // R4 write all ones
      32'h7_1_4_9_00_FF, // R7 wrap
      32'h7_1_0_9_00_00, // R7 wrapped to zero
      32'h8_0_5_A_00_00, // R8 load-linked
      32'h9_0_6_A_11_01, // R9 store-cond succeeds
      32'h9_1_0_A_00_11, // R9 stored
      32'h9_0_6_A_22_00, // R9 reservation consumed
      32'h9_1_0_A_00_11, // R9 failed sc leaves memory
      32'h8_0_5_B_00_00, // R8
      32'hA_1_1_B_33_00, // R10 other port writes same word
      32'hA_0_6_B_44_00, // R10 reservation broken
      32'h9_2_0_B_00_33, // R9 memory unchanged
      32'h8_0_5_C_00_00, // R8
      32'hA_1_1_D_07_00, // R10 write to other address
      32'hA_0_6_C_09_01, // R10 reservation kept
      32'h8_0_5_C_00_09, // R8
      32'h8_0_5_D_00_07, // R8 replaces reservation
      32'hA_1_1_C_01_09, // R10 hits old address only
      32'h8_0_6_D_08_01, // R8 new reservation live
      32'h8_0_6_C_0F_00, // R8 old reservation gone
      32'h8_0_0_C_00_01, // R9 unchanged after fail
      32'h8_1_5_E_00_00, // R8
      32'hA_2_4_E_00_00, // R10 fetch-inc from other port
      32'hA_1_6_E_05_00, // R10 broken by atomic
      32'hA_1_0_E_00_01, // R10 word holds increment
      32'hA_2_5_5_00_00, // R10 own reservation
      32'hA_2_1_5_03_00, // R10 own write
      32'hA_2_6_5_04_01, // R10 own write does not break
      32'hA_2_0_5_00_04, // R10
      32'hA_1_5_8_00_AA, // R10
      32'hA_0_3_8_01_AA, // R10 failed test-and-set
      32'hA_1_6_8_02_01, // R10 reservation survives
      32'hA_1_0_8_00_02, // R10
      32'h4_0_7_8_00_02  // R4 code 7 acts as read
   };

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic drive(input int p, input logic [2:0] op, input logic [AW-1:0] a,
                        input logic [DW-1:0] w);
      req_op[p*3 +: 3]     = op;
      req_addr[p*AW +: AW] = a;
      req_wdata[p*DW +: DW] = w;
      req_valid[p]         = 1'b1;
   endtask

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_bad++;
      n_chk++;
      $display("FAIL R1 watchdog: actual=timeout expected=completion");
      summary();
      $finish;
   end

   initial begin
      // reset behaviour, R11
      @(negedge clk);
      drive(0, 3'd1, 4'h3, 8'hEE);
      @(negedge clk);
      chk(req_ready == '0, "R11", "no grant in reset", 32'(req_ready), 0);
      chk(rsp_valid == '0, "R11", "no response in reset", 32'(rsp_valid), 0);
      req_valid = '0;
      rst = 1'b0;
      @(negedge clk);
      chk(rsp_valid == '0, "R11", "idle after reset", 32'(rsp_valid), 0);

      // rotation among three contenders, R2 and R3
      for (int p = 0; p < NP; p++) drive(p, 3'd0, 4'h0, 8'h00);
      for (int k = 0; k < NP; k++) begin
         #1;
         chk(req_ready == NP'(1 << k), "R2", "rotation grant", 32'(req_ready), 32'(1 << k));
         @(negedge clk);
         req_valid[k] = 1'b0;
         chk(rsp_valid == NP'(1 << k), "R3", "response port", 32'(rsp_valid), 32'(1 << k));
      end
      drive(0, 3'd0, 4'h0, 8'h00);
      drive(1, 3'd0, 4'h0, 8'h00);
      for (int k = 0; k < 4; k++) begin
         #1;
         chk(req_ready == NP'(1 << (k % 2)), "R2", "alternate grant", 32'(req_ready),
             32'(1 << (k % 2)));
         chk($onehot0(req_ready), "R1", "single grant", 32'(req_ready), 32'(1 << (k % 2)));
         @(negedge clk);
      end
      req_valid = '0;
      @(negedge clk);

      // vector table
      for (int i = 0; i < NV; i++) begin
         automatic logic [31:0] v = VEC[i];
         automatic int p = int'(v[27:24]);
         automatic string tag = $sformatf("R%0d", v[31:28]);
         drive(p, v[22:20], v[19:16], v[15:8]);
         #1;
         chk(req_ready == NP'(1 << p), "R1", "lone request granted", 32'(req_ready), 32'(1 << p));
         @(negedge clk);
         req_valid = '0;
         chk(rsp_valid == NP'(1 << p), "R3", "response strobe", 32'(rsp_valid), 32'(1 << p));
         chk(rsp_data[p*DW +: DW] == v[7:0], tag, $sformatf("vector %0d data", i),
             32'(rsp_data[p*DW +: DW]), 32'(v[7:0]));
      end

      // response is a one-cycle pulse, R3
      @(negedge clk);
      chk(rsp_valid == '0, "R3", "strobe drops", 32'(rsp_valid), 0);

      // reset clears memory again, R11
      rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      drive(2, 3'd0, 4'h5, 8'h00);
      @(negedge clk);
      req_valid = '0;
      chk(rsp_data[2*DW +: DW] == 8'h00, "R11", "word cleared", 32'(rsp_data[2*DW +: DW]), 0);

      summary();
      $finish;
   end

endmodule